// File: doc/BRIEF.md
# Three-wire serial EEPROM slave model

This block imitates a small serial EEPROM that talks over a select line, a serial clock and one data line in each direction. It is meant to sit opposite a master controller inside self-checking benches, so a master's framing, timing and data handling can be tested without a real memory part. All inputs are sampled on the system clock, and the serial clock is edge-detected inside the block. Every command bit and every output bit moves on a rising serial clock edge.

A command begins with a 1 start bit. Two opcode bits follow: `10` reads, `01` writes one word, and `00` selects a control command. An address comes next, sent most significant bit first. Its width is `log2(BYTES)` when words are 8 bits wide and one bit less when words are 16 bits wide. For a control command, the two top address bits pick the action:

- `11` sets the write-enable latch.
- `00` clears the write-enable latch.
- `10` erases the whole array.

A read drives a single 0 and then streams words from consecutive addresses for as long as select stays high. Writes and erase-all start a programming period. During that period the data output shows a busy status, and new commands are refused. Two parameters add length to the frames: one puts two trailing bits on control commands, and the other puts one idle clock between the read address and the read data.

Top module: `mw_eeprom_model`

## Requirements
- R1: After reset the write-enable latch is clear, every bit of the array is 1, and `doOut` is high.
- R2: While no command is in progress, 0 bits on `diIn` are skipped; decoding begins at the first 1.
- R3: After the last address bit of a read, `doOut` gives one 0 bit, then the word's bits most significant first, one per rising serial clock edge.
- R4: While select stays high, a read continues with the word at the next address, and it wraps from the last word back to address 0.
- R5: A write or an erase-all received while the write-enable latch is clear leaves the array unchanged and starts no busy period.
- R6: In a control command, address bits [AW-1:AW-2] equal to 11 set the latch, 00 clear it, and 10 (with the latch set) writes 1 to every bit.
- R7: A write with the latch set stores the DW data bits that follow the address, most significant first, at that address.
- R8: For PROG_CYCLES clocks after a write or erase takes effect, `doOut` is low whenever no read is in progress, and start bits are ignored; after that `doOut` returns high.
- R9: Dropping select aborts a partly received command without any effect.
- R10: With LONG_SPECIAL set, a control command takes effect only after two more bits following the address.
- R11: With READ_EXTRA set, one extra serial clock separates the last address bit from the 0 bit of a read; `doOut` stays high on that clock.
- R12: The address is `log2(BYTES)` bits wide for 8-bit words and `log2(BYTES)-1` bits wide for 16-bit words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; samples all serial lines |
| rstN | input | 1 | Active-low synchronous reset |
| csIn | input | 1 | Chip select, active high |
| skIn | input | 1 | Serial clock from the master |
| diIn | input | 1 | Serial data from master to device |
| doOut | output | 1 | Serial data or ready/busy status to master |

## Verification
The bench reads across the top of the array and checks the wrap. A model that stopped at the end, or ran past it, would return wrong words for the second and third reads.

Writes are sent while the latch is clear, after it has been cleared again, and while a previous write is still programming. Each time the target word is read back later, so a design that ignored the latch, or accepted commands while busy, would show the new data.

An aborted write and a control command missing its trailing bits are both checked for having no effect. The read gap is checked by sampling `doOut` on both the extra clock and the 0 bit that follows it. A design that put the gap in the wrong place would be off by one bit on every word it returned.

// File: rtl/mw_pkg.sv
package mw_pkg;
  localparam logic [1:0] OPC_READ  = 2'b10;
  localparam logic [1:0] OPC_WRITE = 2'b01;
  localparam logic [1:0] OPC_CTRL  = 2'b00;

  typedef enum logic [2:0] {
    S_IDLE, S_OPC, S_ADDR, S_GAP, S_READ, S_WDATA, S_TAIL, S_DONE
  } mwState_e;

  typedef struct packed {
    logic shiftAddr;
    logic shiftData;
    logic loadWord;
    logic shiftOut;
    logic nextWord;
    logic commitWrite;
    logic special;
    logic reading;
  } mwStrobe_t;
endpackage

// File: rtl/mw_ctrl.sv
module mw_ctrl
  import mw_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 16,
  parameter bit LONG_SPECIAL = 1'b0,
  parameter bit READ_EXTRA = 1'b0
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      csIn,
  input  logic      skIn,
  input  logic      diIn,
  input  logic      busy,
  output mwStrobe_t stb,
  output mwState_e  state
);
  localparam int MAXN = (AW > DW) ? AW : DW;
  localparam int CW = $clog2(MAXN + 1);
  localparam logic [CW-1:0] ADDR_LAST = CW'(AW - 1);
  localparam logic [CW-1:0] DATA_LAST = CW'(DW - 1);
  localparam logic [CW-1:0] WORD_END  = CW'(DW);

  logic [CW-1:0] cnt;
  logic [1:0] opc;
  logic skQ;
  logic skRise;

  assign skRise = skIn & ~skQ;

  always_comb begin
    stb = '0;
    stb.reading = (state == S_READ);
    if (csIn && skRise) begin
      case (state)
        S_ADDR: begin
          stb.shiftAddr = 1'b1;
          if (cnt == ADDR_LAST) begin
            stb.loadWord = (opc == OPC_READ) && !READ_EXTRA;
            stb.special  = (opc == OPC_CTRL) && !LONG_SPECIAL;
          end
        end
        S_GAP:   stb.loadWord = 1'b1;
        S_TAIL:  stb.special = (cnt == CW'(1));
        S_READ: begin
          stb.nextWord = (cnt == WORD_END);
          stb.shiftOut = (cnt != WORD_END);
        end
        S_WDATA: begin
          stb.shiftData   = 1'b1;
          stb.commitWrite = (cnt == DATA_LAST);
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      cnt   <= '0;
      opc   <= '0;
      skQ   <= 1'b0;
    end else begin
      skQ <= skIn;
      if (!csIn) begin
        state <= S_IDLE;
        cnt   <= '0;
      end else if (skRise) begin
        case (state)
          S_IDLE: begin
            cnt <= '0;
            if (diIn && !busy) state <= S_OPC;
          end
          S_OPC: begin
            opc <= {opc[0], diIn};
            if (cnt == CW'(1)) begin
              state <= S_ADDR;
              cnt   <= '0;
            end else cnt <= cnt + 1'b1;
          end
          S_ADDR: begin
            if (cnt == ADDR_LAST) begin
              cnt <= '0;
              case (opc)
                OPC_READ:  state <= READ_EXTRA ? S_GAP : S_READ;
                OPC_WRITE: state <= S_WDATA;
                OPC_CTRL:  state <= LONG_SPECIAL ? S_TAIL : S_DONE;
                default:   state <= S_DONE;
              endcase
            end else cnt <= cnt + 1'b1;
          end
          S_GAP: begin
            state <= S_READ;
            cnt   <= '0;
          end
          S_READ: cnt <= (cnt == WORD_END) ? CW'(1) : cnt + 1'b1;
          S_WDATA: begin
            if (cnt == DATA_LAST) state <= S_DONE;
            else cnt <= cnt + 1'b1;
          end
          S_TAIL: begin
            if (cnt == CW'(1)) state <= S_DONE;
            else cnt <= cnt + 1'b1;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/mw_datapath.sv
module mw_datapath
  import mw_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 16,
  parameter int PROG_CYCLES = 300
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      diIn,
  input  mwStrobe_t stb,
  output logic      doOut,
  output logic      busy,
  output logic      wel
);
  localparam int WORDS = 1 << AW;
  localparam int PW = $clog2(PROG_CYCLES + 1);
  localparam logic [PW-1:0] PROG_LOAD = PW'(PROG_CYCLES);

  logic [DW-1:0] mem [WORDS];
  logic [AW-1:0] addrReg;
  logic [AW-1:0] addrIn;
  logic [DW-1:0] dataSh;
  logic [DW-1:0] outSh;
  logic [PW-1:0] progCnt;
  logic [1:0] spCode;
  logic doReg;

  assign addrIn = stb.shiftAddr ? {addrReg[AW-2:0], diIn} : addrReg;
  assign spCode = addrIn[AW-1:AW-2];
  assign busy   = (progCnt != '0);
  assign doOut  = doReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg <= '0;
      dataSh  <= '0;
      outSh   <= '0;
      progCnt <= '0;
      wel     <= 1'b0;
      doReg   <= 1'b1;
      for (int i = 0; i < WORDS; i++) mem[i] <= '1;
    end else begin
      if (busy) progCnt <= progCnt - 1'b1;
      if (stb.shiftAddr) addrReg <= addrIn;
      if (stb.shiftData) dataSh <= {dataSh[DW-2:0], diIn};

      if (stb.loadWord) begin
        doReg   <= 1'b0;
        outSh   <= mem[addrIn];
        addrReg <= addrIn + 1'b1;
      end else if (stb.shiftOut) begin
        doReg <= outSh[DW-1];
        outSh <= {outSh[DW-2:0], 1'b0};
      end else if (stb.nextWord) begin
        doReg   <= mem[addrReg][DW-1];
        outSh   <= {mem[addrReg][DW-2:0], 1'b0};
        addrReg <= addrReg + 1'b1;
      end else if (!stb.reading) begin
        doReg <= ~busy;
      end

      if (stb.commitWrite && wel) begin
        mem[addrReg] <= {dataSh[DW-2:0], diIn};
        progCnt      <= PROG_LOAD;
      end

      if (stb.special) begin
        case (spCode)
          2'b11: wel <= 1'b1;
          2'b00: wel <= 1'b0;
          2'b10: if (wel) begin
            for (int i = 0; i < WORDS; i++) mem[i] <= '1;
            progCnt <= PROG_LOAD;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/mw_eeprom_model.sv
module mw_eeprom_model
  import mw_pkg::*;
#(
  parameter int BYTES = 128,
  parameter bit WORD16 = 1'b1,
  parameter bit LONG_SPECIAL = 1'b0,
  parameter bit READ_EXTRA = 1'b0,
  parameter int PROG_CYCLES = 300
) (
  input  logic clk,
  input  logic rstN,
  input  logic csIn,
  input  logic skIn,
  input  logic diIn,
  output logic doOut
);
  localparam int AW = $clog2(BYTES) - (WORD16 ? 1 : 0);
  localparam int DW = WORD16 ? 16 : 8;

  mwStrobe_t stb;
  mwState_e  ctrlState;
  logic busy;
  logic wel;

  mw_ctrl #(
    .AW(AW), .DW(DW), .LONG_SPECIAL(LONG_SPECIAL), .READ_EXTRA(READ_EXTRA)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .csIn(csIn), .skIn(skIn), .diIn(diIn),
    .busy(busy), .stb(stb), .state(ctrlState)
  );

  mw_datapath #(
    .AW(AW), .DW(DW), .PROG_CYCLES(PROG_CYCLES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .diIn(diIn), .stb(stb),
    .doOut(doOut), .busy(busy), .wel(wel)
  );
endmodule

// File: rtl/mw_eeprom_checker.sv
module mw_eeprom_checker
  import mw_pkg::*;
(
  input logic     clk,
  input logic     rstN,
  input logic     csIn,
  input logic     doOut,
  input logic     busy,
  input logic     wel,
  input mwState_e st,
  input logic     loadWord,
  input logic     shiftOut,
  input logic     nextWord,
  input logic     commitWrite
);
  a_r9_cs_low_idle: assert property (@(posedge clk) disable iff (!rstN)
    !csIn |=> st == S_IDLE);

  a_r8_busy_blocks_start: assert property (@(posedge clk) disable iff (!rstN)
    (st == S_IDLE && busy) |=> st == S_IDLE);

  a_r8_status_low: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> !doOut);

  a_r5_no_prog_without_wel: assert property (@(posedge clk) disable iff (!rstN)
    (commitWrite && !wel && !busy) |=> !busy);

  a_r7_write_starts_prog: assert property (@(posedge clk) disable iff (!rstN)
    (commitWrite && wel) |=> busy);

  a_r3_one_out_action: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({loadWord, shiftOut, nextWord}));
endmodule

bind mw_eeprom_model mw_eeprom_checker u_chk (
  .clk(clk), .rstN(rstN), .csIn(csIn), .doOut(doOut), .busy(busy), .wel(wel),
  .st(ctrlState), .loadWord(stb.loadWord), .shiftOut(stb.shiftOut),
  .nextWord(stb.nextWord), .commitWrite(stb.commitWrite)
);

// File: tb/sim_mw_eeprom_model.sv
module sim_mw_eeprom_model;
  localparam int CLK_PERIOD = 10;
  localparam int PROG = 300;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sk = 1'b0;
  logic di = 1'b0;
  logic cs0 = 1'b0;
  logic cs1 = 1'b0;
  logic do0;
  logic do1;

  int nChecks = 0;
  int nFail = 0;
  int sel = 0;
  bit welM = 1'b0;
  int mdl0 [64];
  int mdl1 [256];
  int expQ [$];
  string tagQ [$];
  int obsQ [$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  mw_eeprom_model #(.PROG_CYCLES(PROG)) u0 (
    .clk(clk), .rstN(rstN), .csIn(cs0), .skIn(sk), .diIn(di), .doOut(do0));

  mw_eeprom_model #(
    .BYTES(256), .WORD16(1'b0), .LONG_SPECIAL(1'b1), .READ_EXTRA(1'b1), .PROG_CYCLES(PROG)
  ) u1 (
    .clk(clk), .rstN(rstN), .csIn(cs1), .skIn(sk), .diIn(di), .doOut(do1));

  function automatic int aw(); return (sel != 0) ? 8 : 6; endfunction
  function automatic int dw(); return (sel != 0) ? 8 : 16; endfunction
  function automatic int nWords(); return (sel != 0) ? 256 : 64; endfunction
  function automatic int mget(int a); return (sel != 0) ? mdl1[a] : mdl0[a]; endfunction

  task automatic mset(int a, int v);
    if (sel != 0) mdl1[a] = v; else mdl0[a] = v;
  endtask

  task automatic chk(string tag, int act, int exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clkBit(input logic b, output logic s);
    di = b;
    sk = 1'b0;
    repeat (4) @(negedge clk);
    sk = 1'b1;
    repeat (4) @(negedge clk);
    s = (sel != 0) ? do1 : do0;
  endtask

  task automatic sendBits(input logic [31:0] v, input int n, output logic s);
    for (int i = n - 1; i >= 0; i--) clkBit(v[i], s);
  endtask

  task automatic csOn();
    sk = 1'b0;
    if (sel != 0) cs1 = 1'b1; else cs0 = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic csOff();
    sk = 1'b0;
    di = 1'b0;
    cs0 = 1'b0;
    cs1 = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic control(int code, bit withTail);
    logic s;
    bit runs;
    runs = withTail || (sel == 0);
    csOn();
    clkBit(1'b1, s);
    sendBits(32'b00, 2, s);
    sendBits(32'(code) << (aw() - 2), aw(), s);
    if (withTail && sel != 0) sendBits(32'b00, 2, s);
    csOff();
    if (runs) begin
      if (code == 3) welM = 1'b1;
      if (code == 0) welM = 1'b0;
      if (code == 2 && welM) begin
        for (int a = 0; a < nWords(); a++) mset(a, (1 << dw()) - 1);
        repeat (PROG + 20) @(negedge clk);
      end
    end
  endtask

  task automatic writeWord(int addr, int data, bit takes, bit waitDone);
    logic s;
    csOn();
    clkBit(1'b1, s);
    sendBits(32'b01, 2, s);
    sendBits(32'(addr), aw(), s);
    sendBits(32'(data), dw(), s);
    csOff();
    if (takes) mset(addr, data);
    if (waitDone) repeat (PROG + 20) @(negedge clk);
  endtask

  task automatic readWords(int addr, int n, int lead, string tag);
    logic s;
    int v;
    for (int i = 0; i < n; i++) begin
      expQ.push_back(mget((addr + i) % nWords()));
      tagQ.push_back(tag);
    end
    csOn();
    for (int i = 0; i < lead; i++) clkBit(1'b0, s);
    clkBit(1'b1, s);
    sendBits(32'b10, 2, s);
    sendBits(32'(addr), aw(), s);
    if (sel != 0) begin
      chk("R11 gap clock keeps doOut high", int'(s), 1);
      clkBit(1'b0, s);
      chk("R11 zero bit after gap", int'(s), 0);
    end else begin
      chk("R3 zero bit after address", int'(s), 0);
    end
    for (int w = 0; w < n; w++) begin
      v = 0;
      for (int b = 0; b < dw(); b++) begin
        clkBit(1'b0, s);
        v = (v << 1) | int'(s);
      end
      obsQ.push_back(v);
    end
    csOff();
  endtask

  // scoreboard monitor: pairs each observed word with the oldest expectation
  initial begin
    forever begin
      @(negedge clk);
      while (obsQ.size() > 0 && expQ.size() > 0) begin
        chk(tagQ.pop_front(), obsQ.pop_front(), expQ.pop_front());
      end
    end
  end

  initial begin
    repeat (150000) @(negedge clk);
    nFail++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end

  initial begin
    logic s;
    for (int a = 0; a < 64; a++) mdl0[a] = 'hFFFF;
    for (int a = 0; a < 256; a++) mdl1[a] = 'hFF;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state
    chk("R1 doOut high after reset u0", int'(do0), 1);
    chk("R1 doOut high after reset u1", int'(do1), 1);
    sel = 0;
    readWords(0, 2, 0, "R1 array erased at reset");

    // R5: write with latch clear
    writeWord(5, 'h1234, 1'b0, 1'b0);
    chk("R5 no busy without enable", int'(do0), 1);
    readWords(5, 1, 0, "R5 write ignored while disabled");

    // R6 enable, R7 write, R8 busy status
    control(3, 1'b1);
    writeWord(5, 'h1234, 1'b1, 1'b0);
    chk("R8 busy low after write", int'(do0), 0);
    repeat (PROG + 20) @(negedge clk);
    chk("R8 ready high after program time", int'(do0), 1);
    readWords(5, 1, 0, "R7 written word read back");

    writeWord(63, 'hA5C3, 1'b1, 1'b1);
    writeWord(0, 'h0F0F, 1'b1, 1'b1);
    writeWord(1, 'h8001, 1'b1, 1'b1);
    readWords(63, 3, 0, "R4 sequential read wraps to zero");

    // R2: leading zeros before the start bit
    readWords(5, 1, 3, "R2 leading zeros skipped");

    // R9: aborted write
    csOn();
    clkBit(1'b1, s);
    sendBits(32'b01, 2, s);
    sendBits(32'd5, 6, s);
    sendBits(32'hAB, 8, s);
    csOff();
    chk("R9 abort starts no busy", int'(do0), 1);
    readWords(5, 1, 0, "R9 aborted write has no effect");

    // R8: command while busy is ignored
    writeWord(10, 'h00FF, 1'b1, 1'b0);
    writeWord(10, 'hBEEF, 1'b0, 1'b0);
    repeat (PROG + 20) @(negedge clk);
    readWords(10, 1, 0, "R8 write during busy ignored");

    // R6: disable, then erase gating and erase
    control(0, 1'b1);
    writeWord(10, 'h1111, 1'b0, 1'b1);
    readWords(10, 1, 0, "R6 write after disable ignored");
    control(2, 1'b1);
    readWords(10, 1, 0, "R5 erase ignored while disabled");
    control(3, 1'b1);
    csOn();
    clkBit(1'b1, s);
    sendBits(32'b00, 2, s);
    sendBits(32'b10_0000, 6, s);
    csOff();
    chk("R8 busy low after erase", int'(do0), 0);
    for (int a = 0; a < 64; a++) mdl0[a] = 'hFFFF;
    repeat (PROG + 20) @(negedge clk);
    readWords(10, 1, 0, "R6 erase sets all ones");
    readWords(63, 2, 0, "R6 erase sets all ones at ends");

    // second instance: 8-bit words, 8 address bits, trailing and gap quirks
    sel = 1;
    control(3, 1'b0);
    writeWord(3, 'h5A, 1'b0, 1'b1);
    readWords(3, 1, 0, "R10 enable without tail bits has no effect");
    control(3, 1'b1);
    writeWord(3, 'h5A, 1'b1, 1'b1);
    readWords(3, 1, 0, "R12 byte write at 8-bit address");
    writeWord(255, 'hC3, 1'b1, 1'b1);
    writeWord(0, 'h11, 1'b1, 1'b1);
    readWords(254, 3, 0, "R4 byte mode wrap");
    readWords(3, 1, 0, "R11 read with gap clock");

    repeat (20) @(negedge clk);
    chk("R4 scoreboard drained", expQ.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end
endmodule